// File: doc/BRIEF.md
# Self-Identification Sequencer

This block runs one node's part of the self-identification phase of a serial bus, once the tree of parent and child ports is known. The node is told whether it is the root and which of its ports lead to children. A root starts the phase on its own. Any other node waits for a grant from its parent. While some child ports have not yet reported that they are finished, the node passes the grant down to the lowest-numbered of them. Once no child is left, the node takes its physical ID, emits its own identification packet and reports completion upstream.

The node counts every identification packet it observes, its own included. The count at the moment the node sends gives its physical ID. Because of this, IDs come out in depth-first order, and the root, which sends last, ends with the highest ID. Each packet carries a one-bit flag that marks a node wishing to manage isochronous resources. The block records the ID of the highest-numbered node that set the flag. A root also gives a one-cycle completion pulse when the whole phase is over. Packet serialization, speed exchange and CRC are handled elsewhere. In this block a packet is only a strobe, an ID and a flag.

Top module: `selfid_seq`

## Requirements
- R1: Asynchronous reset (rstN low) and a synchronous busReset each clear the packet counter, the physical ID, the resource-manager result, all per-port done records and the phase state. After either one, physIdValid, irmValid, parentDone, childGrant and pktTx are all 0.
- R2: On phaseStart the node captures isRoot and childMask. A root begins granting straight away. A non-root node issues no grant and sends no packet until parentGrant is high.
- R3: At most one childGrant bit is high at a time. Bit i maps to port i. The grant goes to the lowest-numbered port that has a child and has not yet reported done, and it stays high until that port's childDone bit is seen.
- R4: The packet counter (6 bits) goes up by one for each cycle with pktSeen high and for the node's own packet. It holds at 63.
- R5: When no child port is pending, the node pulses pktTx for one cycle with pktTxId equal to the current count and pktTxIrm equal to wantIrm. physId then holds that value with physIdValid high.
- R6: A non-root node raises parentDone only after it has sent its own packet, and then holds it until reset. It is never raised while a child is still pending.
- R7: A non-root node that sees a child report done drops the grant and waits for a new parentGrant before it grants its next child or sends.
- R8: A root keeps parentDone at 0. Once every child port has reported done, it takes the next ID, sends, and pulses phaseDone high for exactly one cycle on the cycle after its pktTx.
- R9: irmId holds the ID of the last packet seen with its flag set (pktSeenIrm, or wantIrm for the node's own packet), which is the highest-numbered contender. irmValid goes high with the first such packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busReset | input | 1 | Synchronous clear of the whole phase |
| phaseStart | input | 1 | Tree identification finished; capture the configuration |
| isRoot | input | 1 | This node is the root |
| childMask | input | NUM_PORTS | Ports that lead to a child |
| wantIrm | input | 1 | This node contends for resource manager |
| parentGrant | input | 1 | Grant arriving from the parent port |
| parentDone | output | 1 | Self-ID done reported to the parent |
| childGrant | output | NUM_PORTS | Grant passed to one child port |
| childDone | input | NUM_PORTS | Done reported by each child port |
| pktSeen | input | 1 | Another node's self-ID packet was observed |
| pktSeenIrm | input | 1 | Contender flag of the observed packet |
| pktTx | output | 1 | Strobe for the node's own self-ID packet |
| pktTxId | output | ID_W | ID carried in the own packet |
| pktTxIrm | output | 1 | Contender flag carried in the own packet |
| physId | output | ID_W | Assigned physical ID |
| physIdValid | output | 1 | physId has been assigned |
| phaseDone | output | 1 | One-cycle pulse when a root finishes the phase |
| irmId | output | ID_W | ID of the winning resource-manager contender |
| irmValid | output | 1 | At least one contender has been seen |

## Verification
The assertions assume that pktSeen is never high in the same cycle as the node's own pktTx. They also assume that childDone for a port rises only while that port holds the grant, and that isRoot and childMask hold steady from phaseStart until the phase ends. The bench acts as both the neighbours and the parent. It answers each grant on the granted port only, in a separate cycle it reports an observed packet and only then raises that port's done bit, and it changes the configuration only after a busReset. Each scenario begins with a busReset, so the counter and the done records always start from zero.

// File: rtl/selfid_pkg.sv
package selfid_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAITG,
    ST_PICK,
    ST_GRANT,
    ST_SEND,
    ST_FIN
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;
    logic ownPkt;
  } dpCtl_t;

endpackage

// File: rtl/selfid_pick.sv
module selfid_pick #(
  parameter int NUM_PORTS = 4,
  localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic [NUM_PORTS-1:0] pending,
  output logic                 anyPending,
  output logic [PORT_W-1:0]    lowIdx
);

  // lowest set bit wins: scan from the top so the lowest index is written last
  always_comb begin
    lowIdx = '0;
    for (int i = NUM_PORTS - 1; i >= 0; i--) begin
      if (pending[i]) lowIdx = PORT_W'(i);
    end
    anyPending = |pending;
  end

endmodule

// File: rtl/selfid_ctrl.sv
module selfid_ctrl
  import selfid_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busReset,
  input  logic                 phaseStart,
  input  logic                 isRoot,
  input  logic [NUM_PORTS-1:0] childMask,
  input  logic                 parentGrant,
  input  logic [NUM_PORTS-1:0] childDone,
  input  logic                 anyPending,
  input  logic [PORT_W-1:0]    lowIdx,
  output logic [NUM_PORTS-1:0] pendingMask,
  output logic [NUM_PORTS-1:0] childGrant,
  output logic                 parentDone,
  output logic                 pktTx,
  output logic                 phaseDone,
  output dpCtl_t               ctl
);

  seqState_t             state;
  logic                  rootQ;
  logic [NUM_PORTS-1:0]  maskQ;
  logic [NUM_PORTS-1:0]  doneSeen;
  logic [PORT_W-1:0]     grantIdx;
  logic                  phaseDoneQ;
  logic                  startNow;
  logic                  grantDone;

  assign startNow  = (state == ST_IDLE) && phaseStart;
  assign grantDone = (state == ST_GRANT) && childDone[grantIdx];

  // per-port done record
  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_done
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        doneSeen[g] <= 1'b0;
      end else if (busReset || startNow) begin
        doneSeen[g] <= 1'b0;
      end else if (grantDone && (grantIdx == PORT_W'(g))) begin
        doneSeen[g] <= 1'b1;
      end
    end
  end

  assign pendingMask = maskQ & ~doneSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      rootQ      <= 1'b0;
      maskQ      <= '0;
      grantIdx   <= '0;
      phaseDoneQ <= 1'b0;
    end else if (busReset) begin
      state      <= ST_IDLE;
      rootQ      <= 1'b0;
      maskQ      <= '0;
      grantIdx   <= '0;
      phaseDoneQ <= 1'b0;
    end else begin
      phaseDoneQ <= (state == ST_SEND) && rootQ;
      unique case (state)
        ST_IDLE: begin
          if (phaseStart) begin
            rootQ <= isRoot;
            maskQ <= childMask;
            state <= isRoot ? ST_PICK : ST_WAITG;
          end
        end
        ST_WAITG: begin
          if (parentGrant) state <= ST_PICK;
        end
        ST_PICK: begin
          if (anyPending) begin
            grantIdx <= lowIdx;
            state    <= ST_GRANT;
          end else begin
            state <= ST_SEND;
          end
        end
        ST_GRANT: begin
          if (childDone[grantIdx]) state <= rootQ ? ST_PICK : ST_WAITG;
        end
        ST_SEND:  state <= ST_FIN;
        ST_FIN:   state <= ST_FIN;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_PORTS; i++) begin
      childGrant[i] = (state == ST_GRANT) && (grantIdx == PORT_W'(i));
    end
  end

  assign parentDone = (state == ST_FIN) && !rootQ;
  assign pktTx      = (state == ST_SEND);
  assign phaseDone  = phaseDoneQ;
  assign ctl.clear  = busReset;
  assign ctl.ownPkt = (state == ST_SEND);

  // R3: one grant at a time
  a_r3_single_grant: assert property (@(posedge clk) disable iff (!rstN || busReset)
    $onehot0(childGrant));

  // R3: grant held until the granted child reports done
  a_r3_grant_held: assert property (@(posedge clk) disable iff (!rstN || busReset)
    ((|childGrant) && ((childGrant & childDone) == '0)) |=> $stable(childGrant));

  // R6: done is held once raised
  a_r6_done_hold: assert property (@(posedge clk) disable iff (!rstN || busReset)
    parentDone |=> parentDone);

  // R6: no done while a child is still pending
  a_r6_no_early_done: assert property (@(posedge clk) disable iff (!rstN || busReset)
    parentDone |-> (pendingMask == '0));

  // R8: the root never reports upstream
  a_r8_root_silent: assert property (@(posedge clk) disable iff (!rstN || busReset)
    rootQ |-> !parentDone);

  // R8: completion is a single-cycle pulse
  a_r8_pulse: assert property (@(posedge clk) disable iff (!rstN || busReset)
    phaseDone |=> !phaseDone);

  // R2: packet is never sent straight out of idle
  a_r2_no_send_idle: assert property (@(posedge clk) disable iff (!rstN || busReset)
    (state == ST_IDLE) |=> !pktTx);

endmodule

// File: rtl/selfid_dp.sv
module selfid_dp
  import selfid_pkg::*;
#(
  parameter int ID_W = 6,
  localparam logic [ID_W-1:0] ID_MAX = {ID_W{1'b1}}
) (
  input  logic            clk,
  input  logic            rstN,
  input  dpCtl_t          ctl,
  input  logic            pktSeen,
  input  logic            pktSeenIrm,
  input  logic            wantIrm,
  output logic [ID_W-1:0] pktTxId,
  output logic            pktTxIrm,
  output logic [ID_W-1:0] physId,
  output logic            physIdValid,
  output logic [ID_W-1:0] irmId,
  output logic            irmValid
);

  logic [ID_W-1:0] cnt;
  logic            evt;
  logic            flag;

  assign evt  = pktSeen | ctl.ownPkt;
  assign flag = ctl.ownPkt ? wantIrm : pktSeenIrm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt         <= '0;
      physId      <= '0;
      physIdValid <= 1'b0;
      irmId       <= '0;
      irmValid    <= 1'b0;
    end else if (ctl.clear) begin
      cnt         <= '0;
      physId      <= '0;
      physIdValid <= 1'b0;
      irmId       <= '0;
      irmValid    <= 1'b0;
    end else begin
      if (evt) begin
        if (cnt != ID_MAX) cnt <= cnt + 1'b1;
        if (flag) begin
          irmId    <= cnt;
          irmValid <= 1'b1;
        end
      end
      if (ctl.ownPkt) begin
        physId      <= cnt;
        physIdValid <= 1'b1;
      end
    end
  end

  assign pktTxId  = cnt;
  assign pktTxIrm = wantIrm;

  // R4: each observed packet advances the counter by one
  a_r4_count_step: assert property (@(posedge clk) disable iff (!rstN || ctl.clear)
    (pktSeen && (cnt != ID_MAX)) |=> (cnt == $past(cnt) + 1'b1));

  // R4: inputs never report a foreign packet while sending our own
  a_r4_no_collision: assert property (@(posedge clk) disable iff (!rstN || ctl.clear)
    !(pktSeen && ctl.ownPkt));

  // R5: an assigned ID does not move
  a_r5_id_stable: assert property (@(posedge clk) disable iff (!rstN || ctl.clear)
    physIdValid |=> ($stable(physId) && physIdValid));

  // R9: the recorded contender ID only climbs
  a_r9_irm_climbs: assert property (@(posedge clk) disable iff (!rstN || ctl.clear)
    (irmValid && $past(irmValid)) |-> (irmId >= $past(irmId)));

endmodule

// File: rtl/selfid_seq.sv
module selfid_seq
  import selfid_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int ID_W      = 6,
  localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busReset,
  input  logic                 phaseStart,
  input  logic                 isRoot,
  input  logic [NUM_PORTS-1:0] childMask,
  input  logic                 wantIrm,
  input  logic                 parentGrant,
  output logic                 parentDone,
  output logic [NUM_PORTS-1:0] childGrant,
  input  logic [NUM_PORTS-1:0] childDone,
  input  logic                 pktSeen,
  input  logic                 pktSeenIrm,
  output logic                 pktTx,
  output logic [ID_W-1:0]      pktTxId,
  output logic                 pktTxIrm,
  output logic [ID_W-1:0]      physId,
  output logic                 physIdValid,
  output logic                 phaseDone,
  output logic [ID_W-1:0]      irmId,
  output logic                 irmValid
);

  dpCtl_t                ctl;
  logic [NUM_PORTS-1:0]  pendingMask;
  logic                  anyPending;
  logic [PORT_W-1:0]     lowIdx;

  selfid_pick #(.NUM_PORTS(NUM_PORTS)) u_pick (
    .pending    (pendingMask),
    .anyPending (anyPending),
    .lowIdx     (lowIdx)
  );

  selfid_ctrl #(.NUM_PORTS(NUM_PORTS)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .busReset    (busReset),
    .phaseStart  (phaseStart),
    .isRoot      (isRoot),
    .childMask   (childMask),
    .parentGrant (parentGrant),
    .childDone   (childDone),
    .anyPending  (anyPending),
    .lowIdx      (lowIdx),
    .pendingMask (pendingMask),
    .childGrant  (childGrant),
    .parentDone  (parentDone),
    .pktTx       (pktTx),
    .phaseDone   (phaseDone),
    .ctl         (ctl)
  );

  selfid_dp #(.ID_W(ID_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .pktSeen     (pktSeen),
    .pktSeenIrm  (pktSeenIrm),
    .wantIrm     (wantIrm),
    .pktTxId     (pktTxId),
    .pktTxIrm    (pktTxIrm),
    .physId      (physId),
    .physIdValid (physIdValid),
    .irmId       (irmId),
    .irmValid    (irmValid)
  );

endmodule

// File: tb/sim_selfid_seq.sv
`timescale 1ns/1ps
module sim_selfid_seq;

  localparam int NP = 4;
  localparam int IW = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busReset = 1'b0;
  logic          phaseStart = 1'b0;
  logic          isRoot = 1'b0;
  logic [NP-1:0] childMask = '0;
  logic          wantIrm = 1'b0;
  logic          parentGrant = 1'b0;
  logic          parentDone;
  logic [NP-1:0] childGrant;
  logic [NP-1:0] childDone = '0;
  logic          pktSeen = 1'b0;
  logic          pktSeenIrm = 1'b0;
  logic          pktTx;
  logic [IW-1:0] pktTxId;
  logic          pktTxIrm;
  logic [IW-1:0] physId;
  logic          physIdValid;
  logic          phaseDone;
  logic [IW-1:0] irmId;
  logic          irmValid;

  int nRun  = 0;
  int nFail = 0;
  int expQ[$];
  bit finished = 1'b0;

  always #4 clk = ~clk;

  selfid_seq #(.NUM_PORTS(NP), .ID_W(IW)) u0 (
    .clk(clk), .rstN(rstN), .busReset(busReset), .phaseStart(phaseStart),
    .isRoot(isRoot), .childMask(childMask), .wantIrm(wantIrm),
    .parentGrant(parentGrant), .parentDone(parentDone), .childGrant(childGrant),
    .childDone(childDone), .pktSeen(pktSeen), .pktSeenIrm(pktSeenIrm),
    .pktTx(pktTx), .pktTxId(pktTxId), .pktTxIrm(pktTxIrm), .physId(physId),
    .physIdValid(physIdValid), .phaseDone(phaseDone), .irmId(irmId),
    .irmValid(irmValid)
  );

  task automatic chk(input string req, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // driver side of the scoreboard: expected own packet {irm, id}
  task automatic expectPkt(input int id, input int irm);
    expQ.push_back(irm * 64 + id);
  endtask

  // monitor: compare every own packet against the queue
  always @(negedge clk) begin
    if (rstN && pktTx) begin
      if (expQ.size() == 0) begin
        chk("R5 unexpected packet", pktTxIrm * 64 + pktTxId, -1);
      end else begin
        chk("R5 packet id/flag", pktTxIrm * 64 + pktTxId, expQ.pop_front());
      end
    end
  end

  task automatic seen(input bit flagBit);
    pktSeen = 1'b1; pktSeenIrm = flagBit;
    tick(1);
    pktSeen = 1'b0; pktSeenIrm = 1'b0;
  endtask

  task automatic pulseGrant();
    parentGrant = 1'b1;
    tick(1);
    parentGrant = 1'b0;
  endtask

  task automatic doBusReset();
    busReset = 1'b1; childDone = '0;
    tick(1);
    busReset = 1'b0;
  endtask

  task automatic start(input bit root, input logic [NP-1:0] mask, input bit want);
    isRoot = root; childMask = mask; wantIrm = want;
    phaseStart = 1'b1;
    tick(1);
    phaseStart = 1'b0;
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      nRun++; nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    tick(3);
    // R1: reset state
    chk("R1 physIdValid after reset", physIdValid, 0);
    chk("R1 irmValid after reset", irmValid, 0);
    chk("R1 childGrant after reset", childGrant, 0);
    chk("R1 parentDone after reset", parentDone, 0);
    rstN = 1'b1;
    tick(2);

    // Leaf, not root: two foreign packets first, then grant
    doBusReset();
    start(1'b0, 4'b0000, 1'b1);
    tick(3);
    chk("R2 leaf waits for grant (pktTx)", pktTx, 0);
    chk("R2 leaf waits for grant (physIdValid)", physIdValid, 0);
    seen(1'b0);
    seen(1'b0);
    expectPkt(2, 1);
    pulseGrant();          // now PICK
    tick(2);               // SEND seen by monitor, then FIN
    chk("R6 leaf done after send", parentDone, 1);
    chk("R5 leaf physId", physId, 2);
    chk("R9 own flag recorded", irmId, 2);
    chk("R9 irmValid", irmValid, 1);
    tick(3);
    chk("R8 non-root gives no phaseDone", phaseDone, 0);
    chk("R6 done held", parentDone, 1);

    // Bus reset clears everything
    doBusReset();
    chk("R1 physIdValid after bus reset", physIdValid, 0);
    chk("R1 irmValid after bus reset", irmValid, 0);
    chk("R1 parentDone after bus reset", parentDone, 0);

    // Branch, children on ports 0 and 2
    start(1'b0, 4'b0101, 1'b0);
    tick(2);
    chk("R2 branch no grant before parent", childGrant, 0);
    pulseGrant();
    tick(1);
    chk("R3 branch grants port 0", childGrant, 4'b0001);
    seen(1'b1);            // id 0 contender
    childDone = 4'b0001;
    tick(3);
    chk("R7 grant dropped after child done", childGrant, 0);
    chk("R6 no done while child pending", parentDone, 0);
    chk("R7 no send without new grant", physIdValid, 0);
    pulseGrant();
    tick(1);
    chk("R3 branch grants port 2", childGrant, 4'b0100);
    tick(3);
    chk("R3 grant held until done", childGrant, 4'b0100);
    seen(1'b0);            // id 1
    childDone = 4'b0101;
    tick(3);
    chk("R7 waiting again", childGrant, 0);
    expectPkt(2, 0);
    pulseGrant();
    tick(2);
    chk("R5 branch physId", physId, 2);
    chk("R6 branch done", parentDone, 1);
    chk("R9 earlier contender kept", irmId, 0);
    chk("R4 counter via physId step", physIdValid, 1);

    // Root, children on ports 1 and 3
    doBusReset();
    start(1'b1, 4'b1010, 1'b0);
    tick(1);
    chk("R3 root grants lowest port 1", childGrant, 4'b0010);
    seen(1'b1);            // id 0
    childDone = 4'b0010;
    tick(2);
    chk("R3 root moves to port 3", childGrant, 4'b1000);
    seen(1'b0);            // id 1
    seen(1'b1);            // id 2
    expectPkt(3, 0);
    childDone = 4'b1010;
    tick(3);
    chk("R8 phaseDone pulse", phaseDone, 1);
    chk("R8 root no parentDone", parentDone, 0);
    chk("R8 root holds highest id", physId, 3);
    chk("R9 highest contender", irmId, 2);
    tick(1);
    chk("R8 pulse ends", phaseDone, 0);

    // Saturation at 63
    doBusReset();
    start(1'b0, 4'b0000, 1'b0);
    for (int k = 0; k < 70; k++) seen(1'b0);
    expectPkt(63, 0);
    pulseGrant();
    tick(2);
    chk("R4 counter holds at 63", physId, 63);

    tick(2);
    chk("R5 scoreboard drained", expQ.size(), 0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule